// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Engine

This block runs memory machine cycles on an external bus whose low address byte and data byte share one set of lines, while the high address byte has lines of its own. A core asks for one of three cycle kinds: opcode fetch, memory read or memory write. Each request carries a 16-bit address and, for writes, a data byte. The engine then steps through T-states. It shows the address, strobes the address latch enable, and frees the shared lines for memory to drive. It pulses the read or write strobe, captures the read byte and signals completion. It also drives the memory/IO select and the two status lines for each cycle.

The clock is twice the T-state rate, so every T-state lasts two clocks: a first half (phase 0) and a second half (phase 1). The states are IDLE, T1, T2, T3 and T4. The transitions are as follows:
- IDLE goes to T1 when a valid request arrives (*accept*).
- T1 goes to T2, and T2 goes to T3, after phase 1.
- After phase 1 of T3, a fetch goes to T4. A read or write ends there and goes to T1 if a new request is waiting (*chain*), or to IDLE if not (*retire*).
- T4 ends with the same chain-or-retire choice.

A request is taken only in IDLE or in the final clock of a cycle.

Top module: `mux_bus_cycler`

## Requirements
- R1: After reset the engine is idle. It holds `busy`=0, `done`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `io_m`=1, `ad_oe`=0, {`s1`,`s0`}=00 and `pc_step`=0.
- R2: Throughout both halves of T1, `a_hi` shows address bits 15..8 and `ad_out` shows address bits 7..0 with `ad_oe`=1. From T1 to the end of the cycle, `io_m`=0 and `a_hi` holds the high address byte.
- R3: `ale` is high only in the first clock of T1, so it lasts exactly one clock per cycle.
- R4: `req_kind` is coded 0 = opcode fetch, 1 = memory read, 2 = memory write. {`s1`,`s0`} is 11 for a fetch, 10 for a read and 01 for a write, and holds for the whole cycle. A request with `req_kind`=3 is ignored: no cycle starts and `busy` stays 0.
- R5: In fetch and read cycles, `ad_oe`=0 from T2 to the end of the cycle. `rd_n` is low through both halves of T2 and the first half of T3, and high from the second half of T3 on.
- R6: In fetch and read cycles, `rdata` takes the value on `ad_in` at the clock edge that ends the first half of T3. It keeps that value until the next fetch or read capture; a write leaves it unchanged.
- R7: In a write cycle, `ad_out` carries the write byte with `ad_oe`=1 from T2 to the end of T3. `wr_n` is low in T2 and in the first half of T3, and high in the second half of T3. `rd_n` stays high for the whole write cycle.
- R8: A fetch lasts 8 clocks (T1 to T4). A read or write lasts 6 clocks (T1 to T3). T4 has no strobe and `ad_oe`=0. `done` is high for exactly one clock, the second half of the final state.
- R9: `pc_step` pulses for one clock, in the first half of T2, and only in fetch cycles.
- R10: A valid request that is present in the clock where `done` is high is accepted at once. The next clock is the first half of T1 of the new cycle, with no idle clock between the two cycles. A request held while the engine is busy and `done` is low is not taken early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; hold until the cycle starts |
| req_kind | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write |
| req_addr | input | 16 | Memory address of the request |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A machine cycle is in progress |
| done | output | 1 | Final clock of the current cycle |
| rdata | output | 8 | Byte captured by the last fetch or read |
| pc_step | output | 1 | Program counter advance pulse, fetch T2 |
| a_hi | output | 8 | High address byte lines |
| ad_out | output | 8 | Value driven onto the shared address/data lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 8 | Value seen on the shared lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Memory/IO select, low for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The two functions that can land in the same clock are the retirement of one cycle (its `done` clock) and the acceptance of the next request. The bench provokes this by raising a second, and then a third, request while a cycle is still running and holding each until it is taken. Each held request therefore meets the running cycle's `done` clock. The scoreboard marks such items as chained and fails if an idle clock separates `done` from the next `ale`. It also fails if the chained cycle's status, address or strobes show any trace of the request before it.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_NONE  = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } tstate_e;

endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output tstate_e       tstate,
    output logic          phase,
    output cyc_kind_e     kind_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          done
);

    tstate_e nxt;
    logic    phase_nxt;
    logic    last_state;
    logic    accept;

    // Final T-state of the running cycle: T4 for fetch, T3 otherwise
    assign last_state = (tstate == ST_T4) ||
                        (tstate == ST_T3 && kind_q != K_FETCH);
    assign done       = last_state && phase;
    assign accept     = req_valid && (cyc_kind_e'(req_kind) != K_NONE) &&
                        (tstate == ST_IDLE || done);

    always_comb begin
        nxt = tstate;
        unique case (tstate)
            ST_IDLE: nxt = accept ? ST_T1 : ST_IDLE;
            ST_T1:   nxt = phase ? ST_T2 : ST_T1;
            ST_T2:   nxt = phase ? ST_T3 : ST_T2;
            ST_T3: begin
                if (!phase)                nxt = ST_T3;
                else if (kind_q == K_FETCH) nxt = ST_T4;
                else                       nxt = accept ? ST_T1 : ST_IDLE;
            end
            ST_T4:   nxt = !phase ? ST_T4 : (accept ? ST_T1 : ST_IDLE);
            default: nxt = ST_IDLE;
        endcase
        phase_nxt = (nxt == ST_IDLE || nxt != tstate) ? 1'b0 : ~phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tstate  <= ST_IDLE;
            phase   <= 1'b0;
            kind_q  <= K_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            tstate <= nxt;
            phase  <= phase_nxt;
            if (accept) begin
                kind_q  <= cyc_kind_e'(req_kind);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_chain_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid && req_kind != 2'd3) |=> (tstate == ST_T1 && !phase));

    p_idle_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == ST_IDLE) |-> !phase);

endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
    import mbc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tstate_e          tstate,
    input  logic             phase,
    input  cyc_kind_e        kind_q,
    input  logic [AW-1:0]    addr_q,
    input  logic [DW-1:0]    wdata_q,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             io_m,
    output logic             s1,
    output logic             s0,
    output logic             pc_step,
    output logic             busy
);

    localparam int HI_W = AW - DW;

    logic is_wr;
    assign is_wr = (kind_q == K_WRITE);

    always_comb begin
        a_hi    = '0;
        ad_out  = '0;
        ad_oe   = 1'b0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        io_m    = 1'b1;
        s1      = 1'b0;
        s0      = 1'b0;
        pc_step = 1'b0;
        busy    = (tstate != ST_IDLE);
        if (tstate != ST_IDLE) begin
            io_m = 1'b0;
            a_hi = addr_q[AW-1 -: HI_W];
            s1   = (kind_q == K_FETCH) || (kind_q == K_READ);
            s0   = (kind_q == K_FETCH) || is_wr;
        end
        unique case (tstate)
            ST_IDLE: ;
            ST_T1: begin
                ad_out = addr_q[DW-1:0];
                ad_oe  = 1'b1;
                ale    = !phase;
            end
            ST_T2: begin
                if (is_wr) begin
                    ad_out = wdata_q;
                    ad_oe  = 1'b1;
                    wr_n   = 1'b0;
                end else begin
                    rd_n = 1'b0;
                end
                pc_step = (kind_q == K_FETCH) && !phase;
            end
            ST_T3: begin
                if (is_wr) begin
                    ad_out = wdata_q;
                    ad_oe  = 1'b1;
                    wr_n   = phase;
                end else begin
                    rd_n = phase;
                end
            end
            ST_T4: ;
            default: ;
        endcase
    end

    p_ale_one_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && !io_m));

    p_bus_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_pcstep_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_step |=> (!pc_step && !rd_n));

endmodule

// File: rtl/mbc_capture.sv
module mbc_capture
    import mbc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tstate_e       tstate,
    input  logic          phase,
    input  cyc_kind_e     kind_q,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rdata
);

    logic grab;
    assign grab = (tstate == ST_T3) && !phase && (kind_q != K_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata <= '0;
        else if (grab) rdata <= ad_in;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_WRITE) |=> $stable(rdata));

endmodule

// File: rtl/mux_bus_cycler.sv
module mux_bus_cycler
    import mbc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic             pc_step,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             io_m,
    output logic             s1,
    output logic             s0
);

    tstate_e       tstate;
    logic          phase;
    cyc_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    mbc_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .tstate(tstate), .phase(phase), .kind_q(kind_q),
        .addr_q(addr_q), .wdata_q(wdata_q), .done(done)
    );

    mbc_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .tstate(tstate), .phase(phase), .kind_q(kind_q),
        .addr_q(addr_q), .wdata_q(wdata_q),
        .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
        .pc_step(pc_step), .busy(busy)
    );

    mbc_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .tstate(tstate), .phase(phase), .kind_q(kind_q),
        .ad_in(ad_in), .rdata(rdata)
    );

    p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ({s1, s0} == $past({s1, s0})));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && io_m && !ale));

endmodule

// File: tb/sim_mux_bus_cycler.sv
module sim_mux_bus_cycler;

    localparam logic [1:0] KF = 2'd0, KR = 2'd1, KW = 2'd2, KX = 2'd3;

    typedef struct {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wdata;
        bit          chained;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, pc_step, ad_oe, ale, rd_n, wr_n, io_m, s1, s0;
    logic [7:0]  rdata, a_hi, ad_out, ad_in;
    logic [7:0]  lat_lo = '0;

    int checks = 0;
    int errors = 0;
    int issued = 0;
    int retired = 0;
    bit finished = 0;

    item_t sb[$];
    item_t cur;
    int    pos = -1;
    int    gap = 0;
    logic [7:0] last_rd = 8'h00;

    always #10 clk = ~clk;

    mux_bus_cycler u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .pc_step(pc_step), .a_hi(a_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .io_m(io_m), .s1(s1), .s0(s0)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // External address latch and memory model
    always @(negedge ale) lat_lo = ad_out;
    assign ad_in = rd_n ? 8'h00 : mem_val({a_hi, lat_lo});

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares pins against the expected cycle popped from the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pos < 0) begin
                if (ale) begin
                    if (sb.size() == 0) begin
                        chk(0, "R4", "unexpected cycle start", 1, 0);
                    end else begin
                        cur = sb.pop_front();
                        pos = 0;
                        if (cur.chained) chk(gap == 0, "R10", "idle clocks before chained cycle", gap, 0);
                    end
                end else begin
                    gap++;
                end
            end
            if (pos >= 0) begin
                automatic bit fe = (cur.kind == KF);
                automatic bit wr = (cur.kind == KW);
                automatic int len = fe ? 8 : 6;
                automatic logic [1:0] st = fe ? 2'b11 : (wr ? 2'b01 : 2'b10);
                chk({s1, s0} == st, "R4", "status", {s1, s0}, st);
                chk(io_m == 1'b0, "R2", "io_m", io_m, 0);
                chk(a_hi == cur.addr[15:8], "R2", "a_hi", a_hi, cur.addr[15:8]);
                chk(ale == (pos == 0), "R3", "ale", ale, pos == 0);
                chk(pc_step == (fe && pos == 2), "R9", "pc_step", pc_step, fe && pos == 2);
                chk(done == (pos == len - 1), "R8", "done", done, pos == len - 1);
                chk(busy == 1'b1, "R8", "busy", busy, 1);
                if (pos < 2) begin
                    chk(ad_oe && ad_out == cur.addr[7:0], "R2", "low address",
                        {ad_oe, ad_out}, {1'b1, cur.addr[7:0]});
                    chk(rd_n && wr_n, "R2", "strobes in T1", {rd_n, wr_n}, 2'b11);
                end else if (wr && pos < 6) begin
                    chk(ad_oe && ad_out == cur.wdata, "R7", "write data",
                        {ad_oe, ad_out}, {1'b1, cur.wdata});
                    chk(wr_n == (pos == 5), "R7", "wr_n", wr_n, pos == 5);
                    chk(rd_n == 1'b1, "R7", "rd_n in write", rd_n, 1);
                end else if (!wr && pos < 6) begin
                    chk(ad_oe == 1'b0, "R5", "bus released", ad_oe, 0);
                    chk(rd_n == (pos == 5), "R5", "rd_n", rd_n, pos == 5);
                    chk(wr_n == 1'b1, "R5", "wr_n in read", wr_n, 1);
                end else begin
                    chk(!ad_oe && rd_n && wr_n, "R8", "quiet T4",
                        {ad_oe, rd_n, wr_n}, 3'b011);
                end
                if (pos == 5 && !wr) begin
                    last_rd = mem_val(cur.addr);
                    chk(rdata == last_rd, "R6", "captured byte", rdata, last_rd);
                end
                if (pos == 5 && wr)
                    chk(rdata == last_rd, "R6", "rdata kept by write", rdata, last_rd);
                pos++;
                if (pos == len) begin
                    pos = -1;
                    gap = 0;
                    retired++;
                end
            end
        end
    end

    task automatic issue(input logic [1:0] k, input logic [15:0] a,
                         input logic [7:0] d, input bit chained);
        item_t it;
        @(negedge clk);
        it.kind = k; it.addr = a; it.wdata = d; it.chained = chained;
        sb.push_back(it);
        issued++;
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
        do begin
            @(posedge clk);
            #1;
        end while (!ale);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !ale && rd_n && wr_n && io_m && !ad_oe &&
            !s1 && !s0 && !pc_step, "R1", "reset outputs",
            {busy, done, ale, rd_n, wr_n, io_m, ad_oe, s1, s0, pc_step},
            10'b0001110000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !ale, "R1", "idle after reset", {busy, ale}, 0);

        issue(KF, 16'h1234, 8'h00, 0); wait_idle();
        issue(KR, 16'hABCD, 8'h00, 0); wait_idle();
        issue(KW, 16'h00FF, 8'h3C, 0); wait_idle();

        // R4: kind 3 is ignored
        @(negedge clk);
        req_valid = 1'b1; req_kind = KX; req_addr = 16'h5555;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!busy && !ale && io_m, "R4", "kind 3 ignored",
                {busy, ale, io_m}, 3'b001);
        end
        req_valid = 1'b0;

        // R10: chained cycles, done meets the next accept
        issue(KR, 16'h8001, 8'h00, 0);
        issue(KW, 16'h7F80, 8'hA5, 1);
        issue(KF, 16'hFFFF, 8'h00, 1);
        issue(KW, 16'h0000, 8'h99, 1);
        wait_idle();

        for (int i = 0; i < 5; i++) begin
            issue((i % 2 == 0) ? KR : KF, 16'h0101 * i + 16'h2468, 8'h00, 0);
            wait_idle();
        end

        chk(sb.size() == 0 && retired == issued, "R8", "all cycles retired",
            retired, issued);
        chk(rdata == last_rd, "R6", "rdata held while idle", rdata, last_rd);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule